// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Arbiter

This block decides, once per instruction-fetch slot of a graphics processor core, whether an interrupt is entered and which one. It keeps a register of pending requests, a register of per-source enables and a non-maskable request flag. The core supplies its global interrupt-enable flag from the status word. When the core signals a fetch slot, the arbiter picks at most one request. One cycle later it presents a take strobe, the 32-bit vector address to load into the program counter, and a flag that says whether the program counter and then the status word must be pushed. The same strobe tells the core to reset its status register.

The non-maskable request ranks above everything else and ignores both the global flag and the enable register. It is raised by a write to the host control word, and a second bit of that word lets it enter without saving context. Five maskable sources form a fixed priority chain. A maskable entry leaves its pending bit set, so the service routine must clear it through the software clear port.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, the pending bits, the non-maskable flag, the enable register and the skip-save setting are all zero, and take_o is low.
- R2: A pulse on req_i bit k sets pending bit k. A write on clr_wr_i clears the pending bits selected by clr_mask_i. If a request and a clear hit the same bit in the same cycle, the bit ends up set.
- R3: A host control write with bit 8 of hctl_data_i set raises the non-maskable request. Each such write stores bit 9 as the skip-save setting.
- R4: On a fetch slot with the non-maskable request pending, that request is taken even when gie_i is low or no enable bit is set. Its vector is 0xFFFFFEE0 and its pending flag is cleared.
- R5: A non-maskable entry drives save_o low when the skip-save setting is 1 and high when it is 0.
- R6: A maskable source k is taken only if pending bit k, enable bit k and gie_i are all 1 at the fetch slot. Otherwise no maskable entry happens.
- R7: Among eligible maskable sources, the lowest index wins, with these vectors: bit 0 host 0xFFFFFEC0, bit 1 display 0xFFFFFEA0, bit 2 window violation 0xFFFFFE80, bit 3 external 1 0xFFFFFFC0, bit 4 external 2 0xFFFFFFA0.
- R8: A maskable entry always drives save_o high and does not clear its pending bit.
- R9: take_o, vector_o, save_o and st_reset_o are updated on the clock edge that samples fetch_i high, and last one cycle. st_reset_o equals take_o.
- R10: When the non-maskable request and an eligible maskable source are both present, the non-maskable one is taken.
- R11: Without a fetch slot nothing is taken, and the non-maskable flag stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_i | input | 1 | Instruction-fetch slot: arbitrate this cycle |
| gie_i | input | 1 | Global interrupt enable from the status word |
| req_i | input | 5 | Maskable request pulses, bit index = source |
| clr_wr_i | input | 1 | Software clear of pending bits |
| clr_mask_i | input | 5 | Bits to clear |
| en_wr_i | input | 1 | Enable register write |
| en_data_i | input | 5 | New enable value |
| hctl_wr_i | input | 1 | Host control word write |
| hctl_data_i | input | 16 | Host control data (bit 8 raise NMI, bit 9 skip save) |
| take_o | output | 1 | Interrupt entry strobe |
| vector_o | output | 32 | Vector address for the program counter |
| save_o | output | 1 | Push program counter then status |
| st_reset_o | output | 1 | Reset the status register |
| pend_o | output | 5 | Pending maskable bits |
| nmi_pend_o | output | 1 | Non-maskable request pending |

## Verification
The hardest case to reach is the one where the non-maskable flag is pending at a fetch slot while gie_i is low and a maskable source is enabled and pending. In the same cycle a new host write re-raises the flag or changes the skip-save bit. Random stimulus rarely lines these up, so directed steps build that state first: all sources pending and enabled, global flag off, then host writes with both settings of bit 9. After that, a seeded random phase mixes clears, requests and host writes on the same cycles. Every cycle it is compared against a bench model.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
    localparam int NSRC            = 5;
    localparam int VEC_W           = 32;
    localparam int HCTL_W          = 16;
    localparam int HCTL_NMI_BIT    = 8;
    localparam int HCTL_NOSAVE_BIT = 9;
    localparam logic [VEC_W-1:0] NMI_VEC = 32'hFFFF_FEE0;

    // Vector for each maskable source; index order is the priority order.
    function automatic logic [VEC_W-1:0] mask_vec(input int unsigned idx);
        case (idx)
            0:       mask_vec = 32'hFFFF_FEC0;
            1:       mask_vec = 32'hFFFF_FEA0;
            2:       mask_vec = 32'hFFFF_FE80;
            3:       mask_vec = 32'hFFFF_FFC0;
            default: mask_vec = 32'hFFFF_FFA0;
        endcase
    endfunction

    typedef struct packed {
        logic             take;
        logic [VEC_W-1:0] vec;
        logic             save;
    } pick_t;
endpackage

// File: rtl/irq_pending.sv
module irq_pending
    import irq_arb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_i,
    input  logic            clr_wr_i,
    input  logic [NSRC-1:0] clr_mask_i,
    input  logic            nmi_set_i,
    input  logic            nmi_take_i,
    output logic [NSRC-1:0] pend_o,
    output logic            nmi_o
);
    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic            nmi;
    } pst_t;

    pst_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_wr_i) s_d.pend = s_d.pend & ~clr_mask_i;
        s_d.pend = s_d.pend | req_i;          // new request wins over clear
        if (nmi_take_i) s_d.nmi = 1'b0;
        if (nmi_set_i)  s_d.nmi = 1'b1;       // new request wins over take
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend_o = s_q.pend;
    assign nmi_o  = s_q.nmi;

    assert_req_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |=> ((pend_o & $past(req_i)) == $past(req_i)));

    assert_nmi_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_take_i && !nmi_set_i) |=> !nmi_o);
endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_arb_pkg::*;
(
    input  logic [NSRC-1:0] pend_i,
    input  logic [NSRC-1:0] en_i,
    input  logic            gie_i,
    input  logic            nmi_i,
    input  logic            nosave_i,
    output pick_t           pick_o
);
    logic [NSRC-1:0] live;
    logic            found;

    assign live = pend_i & en_i;

    always_comb begin
        pick_o = '0;
        found  = 1'b0;
        if (nmi_i) begin
            pick_o.take = 1'b1;
            pick_o.vec  = NMI_VEC;
            pick_o.save = !nosave_i;
        end else if (gie_i) begin
            for (int i = 0; i < NSRC; i++) begin
                if (live[i] && !found) begin
                    found       = 1'b1;
                    pick_o.take = 1'b1;
                    pick_o.vec  = mask_vec(i);
                    pick_o.save = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_i,
    input  logic              gie_i,
    input  logic [NSRC-1:0]   req_i,
    input  logic              clr_wr_i,
    input  logic [NSRC-1:0]   clr_mask_i,
    input  logic              en_wr_i,
    input  logic [NSRC-1:0]   en_data_i,
    input  logic              hctl_wr_i,
    input  logic [HCTL_W-1:0] hctl_data_i,
    output logic              take_o,
    output logic [VEC_W-1:0]  vector_o,
    output logic              save_o,
    output logic              st_reset_o,
    output logic [NSRC-1:0]   pend_o,
    output logic              nmi_pend_o
);
    typedef struct packed {
        logic [NSRC-1:0]  en;
        logic             nosave;
        logic             take;
        logic [VEC_W-1:0] vec;
        logic             save;
    } ctl_t;

    ctl_t  c_d, c_q;
    pick_t pick;
    logic  nmi_set, nmi_take;

    assign nmi_set  = hctl_wr_i && hctl_data_i[HCTL_NMI_BIT];
    assign nmi_take = fetch_i && nmi_pend_o;

    irq_pending u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req_i),
        .clr_wr_i   (clr_wr_i),
        .clr_mask_i (clr_mask_i),
        .nmi_set_i  (nmi_set),
        .nmi_take_i (nmi_take),
        .pend_o     (pend_o),
        .nmi_o      (nmi_pend_o)
    );

    irq_select u_select (
        .pend_i   (pend_o),
        .en_i     (c_q.en),
        .gie_i    (gie_i),
        .nmi_i    (nmi_pend_o),
        .nosave_i (c_q.nosave),
        .pick_o   (pick)
    );

    always_comb begin
        c_d = c_q;
        if (en_wr_i)   c_d.en     = en_data_i;
        if (hctl_wr_i) c_d.nosave = hctl_data_i[HCTL_NOSAVE_BIT];
        c_d.take = fetch_i && pick.take;
        c_d.save = c_d.take && pick.save;
        if (c_d.take) c_d.vec = pick.vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign take_o     = c_q.take;
    assign vector_o   = c_q.vec;
    assign save_o     = c_q.save;
    assign st_reset_o = c_q.take;

    assert_needs_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(fetch_i));

    assert_nmi_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && nmi_pend_o) |=> (take_o && vector_o == NMI_VEC));

    assert_nmi_save_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && nmi_pend_o) |=> (save_o == !$past(c_q.nosave)));

    assert_gie_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && !nmi_pend_o && !gie_i) |=> !take_o);

    assert_mask_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_i && !nmi_pend_o && !clr_wr_i) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_i = 0, gie_i = 0, clr_wr_i = 0, en_wr_i = 0, hctl_wr_i = 0;
    logic [4:0]  req_i = 0, clr_mask_i = 0, en_data_i = 0;
    logic [15:0] hctl_data_i = 0;
    logic        take_o, save_o, st_reset_o, nmi_pend_o;
    logic [31:0] vector_o;
    logic [4:0]  pend_o;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model of the registered state
    logic [4:0]  m_pend = 0, m_en = 0;
    logic        m_nmi = 0, m_nosave = 0, m_take = 0, m_save = 0;
    logic [31:0] m_vec = 0;

    always #10 clk = ~clk;

    irq_arbiter u_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .fetch_i(fetch_i), .gie_i(gie_i), .req_i(req_i),
        .clr_wr_i(clr_wr_i), .clr_mask_i(clr_mask_i), .en_wr_i(en_wr_i),
        .en_data_i(en_data_i), .hctl_wr_i(hctl_wr_i), .hctl_data_i(hctl_data_i),
        .take_o(take_o), .vector_o(vector_o), .save_o(save_o),
        .st_reset_o(st_reset_o), .pend_o(pend_o), .nmi_pend_o(nmi_pend_o)
    );

    function automatic logic [31:0] src_vec(input int k);
        case (k)
            0: return 32'hFFFFFEC0;
            1: return 32'hFFFFFEA0;
            2: return 32'hFFFFFE80;
            3: return 32'hFFFFFFC0;
            default: return 32'hFFFFFFA0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: advance model, wait edge, compare, drop pulse inputs
    task automatic tick();
        logic        t = 0, s = 0;
        logic [31:0] v = 0;
        logic [4:0]  live;
        live = m_pend & m_en;
        if (m_nmi) begin
            t = 1; v = 32'hFFFFFEE0; s = !m_nosave;
        end else if (gie_i) begin
            for (int k = 4; k >= 0; k--)
                if (live[k]) begin t = 1; v = src_vec(k); s = 1; end
        end
        m_take = fetch_i && t;
        m_save = m_take && s;
        if (m_take) m_vec = v;
        if (fetch_i && m_nmi) m_nmi = 0;
        if (hctl_wr_i && hctl_data_i[8]) m_nmi = 1;
        if (clr_wr_i) m_pend = m_pend & ~clr_mask_i;
        m_pend = m_pend | req_i;
        if (en_wr_i) m_en = en_data_i;
        if (hctl_wr_i) m_nosave = hctl_data_i[9];
        @(posedge clk);
        @(negedge clk);
        chk("R9 take", {31'd0, take_o}, {31'd0, m_take});
        chk("R9 st_reset", {31'd0, st_reset_o}, {31'd0, m_take});
        if (m_take) begin
            chk("R7 vector", vector_o, m_vec);
            chk("R5 save", {31'd0, save_o}, {31'd0, m_save});
        end
        chk("R2 pending", {27'd0, pend_o}, {27'd0, m_pend});
        chk("R4 nmi flag", {31'd0, nmi_pend_o}, {31'd0, m_nmi});
        fetch_i = 0; req_i = 0; clr_wr_i = 0; en_wr_i = 0; hctl_wr_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 take", {31'd0, take_o}, 32'd0);
        chk("R1 pend", {27'd0, pend_o}, 32'd0);
        chk("R1 nmi", {31'd0, nmi_pend_o}, 32'd0);

        en_wr_i = 1; en_data_i = 5'h1F; req_i = 5'h1F; tick();
        chk("R2 all set", {27'd0, pend_o}, 32'h1F);
        gie_i = 0; fetch_i = 1; tick();
        chk("R6 gie low no take", {31'd0, take_o}, 32'd0);
        gie_i = 1; fetch_i = 1; tick();
        chk("R7 host first", vector_o, 32'hFFFFFEC0);
        chk("R8 save high", {31'd0, save_o}, 32'd1);
        chk("R8 pending kept", {27'd0, pend_o}, 32'h1F);
        clr_wr_i = 1; clr_mask_i = 5'h01; tick();
        fetch_i = 1; tick();
        chk("R7 display next", vector_o, 32'hFFFFFEA0);
        clr_wr_i = 1; clr_mask_i = 5'h0E; tick();
        fetch_i = 1; tick();
        chk("R7 ext2 last", vector_o, 32'hFFFFFFA0);
        clr_wr_i = 1; clr_mask_i = 5'h10; req_i = 5'h10; tick();
        chk("R2 set beats clear", {27'd0, pend_o}, 32'h10);

        gie_i = 0;
        hctl_wr_i = 1; hctl_data_i = 16'h0100; tick();
        chk("R3 nmi raised", {31'd0, nmi_pend_o}, 32'd1);
        tick();
        chk("R11 no fetch no take", {31'd0, take_o}, 32'd0);
        chk("R11 nmi kept", {31'd0, nmi_pend_o}, 32'd1);
        gie_i = 1; fetch_i = 1; tick();
        chk("R10 nmi over maskable", vector_o, 32'hFFFFFEE0);
        chk("R5 save when bit9 clear", {31'd0, save_o}, 32'd1);
        chk("R4 nmi cleared", {31'd0, nmi_pend_o}, 32'd0);
        gie_i = 0; en_wr_i = 1; en_data_i = 0;
        hctl_wr_i = 1; hctl_data_i = 16'h0300; tick();
        fetch_i = 1; tick();
        chk("R4 nmi ignores gie", {31'd0, take_o}, 32'd1);
        chk("R5 skip save", {31'd0, save_o}, 32'd0);
        gie_i = 1; fetch_i = 1; tick();
        chk("R6 disabled source no take", {31'd0, take_o}, 32'd0);

        for (int n = 0; n < 4000; n++) begin
            fetch_i = ($urandom % 2) == 0;
            for (int b = 0; b < 5; b++) req_i[b] = ($urandom % 8) == 0;
            clr_wr_i = ($urandom % 4) == 0;
            clr_mask_i = 5'($urandom);
            en_wr_i = ($urandom % 16) == 0;
            en_data_i = 5'($urandom);
            hctl_wr_i = ($urandom % 20) == 0;
            hctl_data_i = 16'($urandom) & 16'h0300;
            if (($urandom % 4) == 0) gie_i = ~gie_i;
            tick();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule